// File: doc/BRIEF.md
# Remote Terminal Message Sequence Error Detector

This block sits behind the word decoder of a serial command/response bus remote terminal. It follows the stream of decoded word events (a strobe per word, its sync type and a decode-valid flag) together with a bus-quiet indication, and tracks where the terminal stands in the current message. When a word arrives that the message does not allow, when the bus stays quiet where a word is due, or when the bus wakes up too early after a finished message, it sets a sticky flag in a 16-bit error word and raises a one-cycle error pulse.

Message order depends on the command type presented with the command word. A receive command expects a counted run of contiguous data words. A transmit command hands the bus to the terminal's own transmitter and needs transmit data to be ready. A terminal-to-terminal receive command expects a second command word, then the other terminal's status word, then the data words. Timing windows are counted in clock cycles from a cycles-per-microsecond parameter. The terminal address parity is judged once, on the first clock after reset.

Top module: `mseq_err_detect`

## Requirements
- R1: A word strobe with word_ok low sets bit 1 (Manchester) and abandons the current message; the detector then expects a command word.
- R2: A word whose sync type is wrong sets bit 2 (sync): a data sync (word_is_cmd=0) where a command, second command or status word is expected, or a command sync during the data words of a receive.
- R3: After a receive command, 4 us of quiet before the first data word sets bits 3 and 0; after a terminal-to-terminal command, 4 us of quiet before the second command sets bit 3; any word during the response window after a transmit command sets bit 3, while 4 us of quiet there ends the message with no error.
- R4: After the last data word of a receive, any bus activity (bus_quiet low or a strobe) before 4 us of quiet sets bit 4 (gap); 4 us of quiet ends the message with no error.
- R5: During a receive, once at least one data word has arrived, 4 us of quiet while more words are due sets bits 5 (contiguity) and 0 (no-receive); activity on the 4*CYC_PER_US-th quiet cycle or earlier restarts the window.
- R6: In a terminal-to-terminal transfer, 15 us of quiet (15*CYC_PER_US cycles) after the second command without a status word sets bit 0; a status word inside the window continues the message.
- R7: A transmit command (cmd_kind 2'b01) accepted while tx_fifo_empty is high sets bit 7 (FIFO).
- R8: On the first clock after reset release the odd parity of {rt_addr, rt_addr_par} is judged; even parity sets bit 9, which stays set until the next reset and is not changed by later address inputs or by auto-clear.
- R9: Flags are sticky while auto_clr is low; with auto_clr high, bits 0 to 7 clear after 2*CYC_PER_US consecutive cycles with a message flag set and no new error.
- R10: err_pulse is high for one cycle exactly when an error was detected in the preceding cycle, at the same edge as the flag it sets.
- R11: After reset err_reg and err_pulse are 0; bits 6, 8 and 10 to 15 always read 0.
- R12: cmd_kind encodes 2'b00 receive, 2'b01 transmit, 2'b1x terminal-to-terminal receive; cmd_words gives the data word count with 0 meaning 32, and the receive completes on exactly that many data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| word_stb | input | 1 | One-cycle strobe per decoded word |
| word_is_cmd | input | 1 | Sync type of the word: 1 command/status, 0 data |
| word_ok | input | 1 | Word decoded without encoding, bit-count or parity fault |
| bus_quiet | input | 1 | No activity on the active bus this cycle |
| cmd_kind | input | 2 | Command type, valid with a command word strobe |
| cmd_words | input | WC_W | Data word count of the command, 0 means 32 |
| tx_fifo_empty | input | 1 | Transmit data FIFO holds no word |
| rt_addr | input | 5 | Strapped terminal address |
| rt_addr_par | input | 1 | Strapped address parity bit (odd) |
| auto_clr | input | 1 | Auto-clear enable for message flags |
| err_reg | output | 16 | Sticky error flags |
| err_pulse | output | 1 | One-cycle pulse per detected error |

## Verification
The bench drives well-formed receive, transmit and terminal-to-terminal messages, and the same messages broken in one place each: a bad word, a wrong sync, quiet where a word is due, early activity after completion and an empty transmit FIFO. Clean messages separate real faults from false alarms, and the broken ones show that each fault lands in its own bit alone. Timers are probed one cycle before and at their limits, so an off-by-one window is caught. Word counts of 2, 3 and 0 (as 32) tell the completion count apart from the contiguity check.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RXD  = 3'd1,
    ST_TXW  = 3'd2,
    ST_CMD2 = 3'd3,
    ST_STAT = 3'd4,
    ST_POST = 3'd5
  } mseq_state_e;

  localparam int ERR_W   = 16;
  localparam int B_NORCV = 0;
  localparam int B_MAN   = 1;
  localparam int B_SYNC  = 2;
  localparam int B_SEQ   = 3;
  localparam int B_GAP   = 4;
  localparam int B_CON   = 5;
  localparam int B_FIFO  = 7;
  localparam int B_PAR   = 9;

  localparam logic [ERR_W-1:0] MSG_MASK = 16'h00BF;
  localparam logic [ERR_W-1:0] PAR_MASK = 16'h0200;

endpackage

// File: rtl/mseq_quiet_timer.sv
module mseq_quiet_timer #(
  parameter int LIMIT = 240,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_quiet,
  input  logic          word_stb,
  output logic [TW-1:0] tmr_q
);

  logic [TW-1:0] tmr_d;
  logic          restart;
  logic          at_top;

  always_comb begin
    restart = word_stb | ~bus_quiet;
    at_top  = (tmr_q == TW'(LIMIT));
    if (restart) begin
      tmr_d = '0;
    end else if (at_top) begin
      tmr_d = tmr_q;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_d;
    end
  end

  // R5: any activity restarts the quiet window
  p_tmr_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb || !bus_quiet) |=> (tmr_q == '0));

  p_tmr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == TW'(LIMIT)) |=> (tmr_q == TW'(LIMIT)) || (tmr_q == '0));

endmodule

// File: rtl/mseq_order_fsm.sv
module mseq_order_fsm
  import mseq_pkg::*;
#(
  parameter int CON_LIM  = 64,
  parameter int GAP_LIM  = 64,
  parameter int RESP_LIM = 240,
  parameter int TW       = 8,
  parameter int WC_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_stb,
  input  logic             word_is_cmd,
  input  logic             word_ok,
  input  logic             bus_quiet,
  input  logic [1:0]       cmd_kind,
  input  logic [WC_W-1:0]  cmd_words,
  input  logic             tx_fifo_empty,
  input  logic [TW-1:0]    tmr_q,
  output logic [ERR_W-1:0] set_vec
);

  localparam int CW = WC_W + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(1 << WC_W);

  mseq_state_e   st_q, st_d;
  logic [CW-1:0] need_q, need_d;
  logic [CW-1:0] got_q, got_d;
  logic [CW-1:0] words_dec;
  logic          quiet_edge;
  logic          hit_con, hit_gap, hit_resp;

  always_comb begin
    words_dec  = (cmd_words == '0) ? FULL_CNT : {1'b0, cmd_words};
    quiet_edge = bus_quiet & ~word_stb;
    hit_con    = quiet_edge & (tmr_q == TW'(CON_LIM - 1));
    hit_gap    = quiet_edge & (tmr_q == TW'(GAP_LIM - 1));
    hit_resp   = quiet_edge & (tmr_q == TW'(RESP_LIM - 1));
  end

  always_comb begin
    st_d    = st_q;
    need_d  = need_q;
    got_d   = got_q;
    set_vec = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (word_stb) begin
          if (!word_ok) begin
            set_vec[B_MAN] = 1'b1;
          end else if (!word_is_cmd) begin
            set_vec[B_SYNC] = 1'b1;
          end else if (cmd_kind[1]) begin
            st_d   = ST_CMD2;
            need_d = words_dec;
          end else if (cmd_kind[0]) begin
            if (tx_fifo_empty) set_vec[B_FIFO] = 1'b1;
            else               st_d = ST_TXW;
          end else begin
            st_d   = ST_RXD;
            need_d = words_dec;
            got_d  = '0;
          end
        end
      end
      ST_RXD: begin
        if (word_stb) begin
          if (!word_ok) begin
            set_vec[B_MAN] = 1'b1;
            st_d = ST_IDLE;
          end else if (word_is_cmd) begin
            set_vec[B_SYNC] = 1'b1;
            st_d = ST_IDLE;
          end else if (got_q + 1'b1 == need_q) begin
            st_d = ST_POST;
          end else begin
            got_d = got_q + 1'b1;
          end
        end else if (hit_con) begin
          set_vec[B_NORCV] = 1'b1;
          if (got_q == '0) set_vec[B_SEQ] = 1'b1;
          else             set_vec[B_CON] = 1'b1;
          st_d = ST_IDLE;
        end
      end
      ST_TXW: begin
        if (word_stb) begin
          if (!word_ok) set_vec[B_MAN] = 1'b1;
          else          set_vec[B_SEQ] = 1'b1;
          st_d = ST_IDLE;
        end else if (hit_con) begin
          st_d = ST_IDLE;
        end
      end
      ST_CMD2, ST_STAT: begin
        if (word_stb) begin
          if (!word_ok) begin
            set_vec[B_MAN] = 1'b1;
            st_d = ST_IDLE;
          end else if (!word_is_cmd) begin
            set_vec[B_SYNC] = 1'b1;
            st_d = ST_IDLE;
          end else if (st_q == ST_CMD2) begin
            st_d = ST_STAT;
          end else begin
            st_d  = ST_RXD;
            got_d = '0;
          end
        end else if (st_q == ST_CMD2 && hit_con) begin
          set_vec[B_SEQ] = 1'b1;
          st_d = ST_IDLE;
        end else if (st_q == ST_STAT && hit_resp) begin
          set_vec[B_NORCV] = 1'b1;
          st_d = ST_IDLE;
        end
      end
      ST_POST: begin
        if (word_stb || !bus_quiet) begin
          set_vec[B_GAP] = 1'b1;
          st_d = ST_IDLE;
        end else if (hit_gap) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      need_q <= '0;
      got_q  <= '0;
    end else begin
      st_q   <= st_d;
      need_q <= need_d;
      got_q  <= got_d;
    end
  end

  // R1: a detected fault abandons the message
  p_abort_on_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> (st_q == ST_IDLE));

  // R4: the post-message window is entered only from the data phase
  p_post_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_POST) && ($past(st_q) != ST_POST)) |-> ($past(st_q) == ST_RXD));

  // R12: the received-word counter stays below the expected count
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RXD) |-> (got_q < need_q));

endmodule

// File: rtl/mseq_err_flags.sv
module mseq_err_flags
  import mseq_pkg::*;
#(
  parameter int CLR_LIM = 32,
  parameter int CW      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set_vec,
  input  logic [4:0]       rt_addr,
  input  logic             rt_addr_par,
  input  logic             auto_clr,
  output logic [ERR_W-1:0] flags_q,
  output logic             err_pulse
);

  logic             armed_q;
  logic             par_bad;
  logic [ERR_W-1:0] set_all;
  logic [ERR_W-1:0] flags_d;
  logic [CW-1:0]    clr_q, clr_d;
  logic             msg_live;
  logic             do_clr;
  logic             pulse_d;

  always_comb begin
    par_bad  = armed_q & ~(^{rt_addr, rt_addr_par});
    set_all  = (set_vec & MSG_MASK) | (par_bad ? PAR_MASK : '0);
    msg_live = |(flags_q & MSG_MASK);
    do_clr   = 1'b0;
    clr_d    = '0;
    if (auto_clr && msg_live && (set_all == '0)) begin
      if (clr_q == CW'(CLR_LIM - 1)) begin
        do_clr = 1'b1;
      end else begin
        clr_d = clr_q + 1'b1;
      end
    end
    flags_d = (do_clr ? (flags_q & PAR_MASK) : flags_q) | set_all;
    pulse_d = |set_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b1;
      flags_q   <= '0;
      clr_q     <= '0;
      err_pulse <= 1'b0;
    end else begin
      armed_q   <= 1'b0;
      flags_q   <= flags_d;
      clr_q     <= clr_d;
      err_pulse <= pulse_d;
    end
  end

  // R8: parity flag holds until reset
  p_par_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[B_PAR] |=> flags_q[B_PAR]);

  // R8: parity is judged only on the first clock
  p_par_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !flags_q[B_PAR]) |=> !flags_q[B_PAR]);

  // R9: no flag drops while auto-clear is off
  p_keep_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R10: a pulse always comes with a set flag
  p_pulse_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (flags_q != '0));

endmodule

// File: rtl/mseq_err_detect.sv
module mseq_err_detect
  import mseq_pkg::*;
#(
  parameter int CYC_PER_US = 16,
  parameter int WC_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_stb,
  input  logic             word_is_cmd,
  input  logic             word_ok,
  input  logic             bus_quiet,
  input  logic [1:0]       cmd_kind,
  input  logic [WC_W-1:0]  cmd_words,
  input  logic             tx_fifo_empty,
  input  logic [4:0]       rt_addr,
  input  logic             rt_addr_par,
  input  logic             auto_clr,
  output logic [ERR_W-1:0] err_reg,
  output logic             err_pulse
);

  localparam int CON_LIM  = 4 * CYC_PER_US;
  localparam int GAP_LIM  = 4 * CYC_PER_US;
  localparam int RESP_LIM = 15 * CYC_PER_US;
  localparam int CLR_LIM  = 2 * CYC_PER_US;
  localparam int TW       = $clog2(RESP_LIM + 1);
  localparam int CLW      = $clog2(CLR_LIM + 1);

  logic [TW-1:0]    tmr_q;
  logic [ERR_W-1:0] set_vec;

  mseq_quiet_timer #(
    .LIMIT (RESP_LIM),
    .TW    (TW)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_quiet (bus_quiet),
    .word_stb  (word_stb),
    .tmr_q     (tmr_q)
  );

  mseq_order_fsm #(
    .CON_LIM  (CON_LIM),
    .GAP_LIM  (GAP_LIM),
    .RESP_LIM (RESP_LIM),
    .TW       (TW),
    .WC_W     (WC_W)
  ) i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_stb      (word_stb),
    .word_is_cmd   (word_is_cmd),
    .word_ok       (word_ok),
    .bus_quiet     (bus_quiet),
    .cmd_kind      (cmd_kind),
    .cmd_words     (cmd_words),
    .tx_fifo_empty (tx_fifo_empty),
    .tmr_q         (tmr_q),
    .set_vec       (set_vec)
  );

  mseq_err_flags #(
    .CLR_LIM (CLR_LIM),
    .CW      (CLW)
  ) i_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_vec     (set_vec),
    .rt_addr     (rt_addr),
    .rt_addr_par (rt_addr_par),
    .auto_clr    (auto_clr),
    .flags_q     (err_reg),
    .err_pulse   (err_pulse)
  );

  // R11: unused positions never read 1
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reg & ~(MSG_MASK | PAR_MASK)) == '0);

endmodule

// File: tb/test_mseq_err_detect.sv
`timescale 1ns/1ps
module test_mseq_err_detect;

  localparam int CPU  = 4;
  localparam int CON  = 4 * CPU;
  localparam int GAPL = 4 * CPU;
  localparam int RESP = 15 * CPU;
  localparam int CLR  = 2 * CPU;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_stb = 1'b0;
  logic        word_is_cmd = 1'b0;
  logic        word_ok = 1'b1;
  logic        bus_quiet = 1'b1;
  logic [1:0]  cmd_kind = 2'b00;
  logic [4:0]  cmd_words = 5'd0;
  logic        tx_fifo_empty = 1'b0;
  logic [4:0]  rt_addr = 5'b00001;
  logic        rt_addr_par = 1'b0;
  logic        auto_clr = 1'b0;
  logic [15:0] err_reg;
  logic        err_pulse;

  int    checks = 0;
  int    errs = 0;
  int    cyc_cnt = 0;
  string cur_req = "R11";

  // reference model state
  int          m_st = 0;   // 0 idle 1 rx 2 tx 3 cmd2 4 stat 5 post
  int          m_need = 0;
  int          m_got = 0;
  int          m_tmr = 0;
  int          m_clr = 0;
  int          m_armed = 1;
  logic [15:0] m_flags = '0;
  logic        m_pulse = 1'b0;

  always #2 clk = ~clk;

  mseq_err_detect #(.CYC_PER_US(CPU), .WC_W(5)) i_mseq_err_detect (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_is_cmd(word_is_cmd),
    .word_ok(word_ok), .bus_quiet(bus_quiet), .cmd_kind(cmd_kind),
    .cmd_words(cmd_words), .tx_fifo_empty(tx_fifo_empty), .rt_addr(rt_addr),
    .rt_addr_par(rt_addr_par), .auto_clr(auto_clr), .err_reg(err_reg),
    .err_pulse(err_pulse)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_need = 0; m_got = 0; m_tmr = 0; m_clr = 0;
      m_armed = 1; m_flags = '0; m_pulse = 1'b0;
    end else begin
      logic [15:0] s;
      bit q;
      s = '0;
      q = bus_quiet && !word_stb;
      case (m_st)
        0: if (word_stb) begin
             if (!word_ok) s[1] = 1;
             else if (!word_is_cmd) s[2] = 1;
             else if (cmd_kind[1]) begin m_st = 3; m_need = (cmd_words == 0) ? 32 : cmd_words; end
             else if (cmd_kind[0]) begin if (tx_fifo_empty) s[7] = 1; else m_st = 2; end
             else begin m_st = 1; m_need = (cmd_words == 0) ? 32 : cmd_words; m_got = 0; end
           end
        1: if (word_stb) begin
             if (!word_ok) begin s[1] = 1; m_st = 0; end
             else if (word_is_cmd) begin s[2] = 1; m_st = 0; end
             else begin m_got++; if (m_got == m_need) m_st = 5; end
           end else if (q && m_tmr == CON - 1) begin
             s[0] = 1; if (m_got == 0) s[3] = 1; else s[5] = 1; m_st = 0;
           end
        2: if (word_stb) begin
             if (!word_ok) s[1] = 1; else s[3] = 1; m_st = 0;
           end else if (q && m_tmr == CON - 1) m_st = 0;
        3, 4: if (word_stb) begin
             if (!word_ok) begin s[1] = 1; m_st = 0; end
             else if (!word_is_cmd) begin s[2] = 1; m_st = 0; end
             else if (m_st == 3) m_st = 4;
             else begin m_st = 1; m_got = 0; end
           end else if (m_st == 3 && q && m_tmr == CON - 1) begin s[3] = 1; m_st = 0; end
           else if (m_st == 4 && q && m_tmr == RESP - 1) begin s[0] = 1; m_st = 0; end
        default: if (word_stb || !bus_quiet) begin s[4] = 1; m_st = 0; end
                 else if (q && m_tmr == GAPL - 1) m_st = 0;
      endcase
      if (m_armed == 1 && ((^rt_addr) == rt_addr_par)) s[9] = 1;
      m_armed = 0;
      if (auto_clr && ((m_flags & 16'h00BF) != 0) && s == 0) begin
        if (m_clr == CLR - 1) begin m_flags = m_flags & 16'h0200; m_clr = 0; end
        else m_clr++;
      end else m_clr = 0;
      m_flags = m_flags | s;
      m_pulse = (s != 0);
      if (!q) m_tmr = 0; else if (m_tmr < RESP) m_tmr++;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (err_reg !== m_flags || err_pulse !== m_pulse) begin
        errs++;
        $display("FAIL %s: err_reg=%h pulse=%b expected err_reg=%h pulse=%b",
                 cur_req, err_reg, err_pulse, m_flags, m_pulse);
      end
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 20000) begin
      errs++; checks++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin word_stb = 0; bus_quiet = 1; @(negedge clk); end
  endtask

  task automatic busy(input int n);
    for (int i = 0; i < n; i++) begin word_stb = 0; bus_quiet = 0; @(negedge clk); end
  endtask

  task automatic send(input logic is_cmd, input logic ok, input logic [1:0] kind,
                      input logic [4:0] words, input logic fe);
    busy(3);
    word_stb = 1; bus_quiet = 0; word_is_cmd = is_cmd; word_ok = ok;
    cmd_kind = kind; cmd_words = words; tx_fifo_empty = fe;
    @(negedge clk);
    word_stb = 0; word_ok = 1; tx_fifo_empty = 0;
  endtask

  task automatic data(input int n);
    for (int i = 0; i < n; i++) send(0, 1, 2'b00, 5'd0, 0);
  endtask

  task automatic clear_all();
    string keep;
    keep = cur_req; cur_req = "R9";
    auto_clr = 1; quiet(12); auto_clr = 0;
    chk("R9 auto-clear", err_reg, 16'h0000);
    cur_req = keep;
  endtask

  task automatic do_reset(input logic [4:0] a, input logic p);
    rst_n = 0; rt_addr = a; rt_addr_par = p; auto_clr = 0;
    quiet(3);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    do_reset(5'b00001, 1'b0);
    chk("R11 reset err_reg", err_reg, 16'h0000);
    chk("R11 reset pulse", {15'd0, err_pulse}, 16'h0000);

    cur_req = "R12";
    send(1, 1, 2'b00, 5'd2, 0); data(2); quiet(20);
    chk("R12 two-word receive clean", err_reg, 16'h0000);

    cur_req = "R4";
    send(1, 1, 2'b00, 5'd1, 0); data(1); quiet(5); busy(1);
    chk("R4 early activity after message", err_reg, 16'h0010);
    busy(1); quiet(30);
    chk("R9 flag sticky with auto-clear off", err_reg, 16'h0010);
    clear_all();
    send(1, 1, 2'b00, 5'd1, 0); data(1); quiet(GAPL); busy(2); quiet(2);
    chk("R4 activity after full gap", err_reg, 16'h0000);

    cur_req = "R1";
    send(1, 0, 2'b00, 5'd1, 0);
    chk("R1 bad word", err_reg, 16'h0002);
    chk("R10 pulse on detection", {15'd0, err_pulse}, 16'h0001);
    quiet(1);
    chk("R10 pulse lasts one cycle", {15'd0, err_pulse}, 16'h0000);
    clear_all();
    send(1, 1, 2'b00, 5'd3, 0); data(1); send(0, 0, 2'b00, 5'd0, 0); quiet(20);
    chk("R1 bad data word only manchester", err_reg, 16'h0002);
    clear_all();

    cur_req = "R2";
    send(0, 1, 2'b00, 5'd0, 0);
    chk("R2 data sync when idle", err_reg, 16'h0004);
    clear_all();
    send(1, 1, 2'b00, 5'd2, 0); send(1, 1, 2'b00, 5'd2, 0); quiet(20);
    chk("R2 command sync in data phase", err_reg, 16'h0004);
    clear_all();
    send(1, 1, 2'b10, 5'd1, 0); send(0, 1, 2'b00, 5'd0, 0);
    chk("R2 data sync as second command", err_reg, 16'h0004);
    clear_all();

    cur_req = "R3";
    send(1, 1, 2'b00, 5'd2, 0); quiet(CON - 1);
    chk("R3 one cycle before window", err_reg, 16'h0000);
    quiet(1);
    chk("R3 quiet after receive command", err_reg, 16'h0009);
    clear_all();
    send(1, 1, 2'b01, 5'd1, 0); send(0, 1, 2'b00, 5'd0, 0);
    chk("R3 word after transmit command", err_reg, 16'h0008);
    clear_all();
    send(1, 1, 2'b01, 5'd1, 0); quiet(20);
    chk("R3 transmit then quiet clean", err_reg, 16'h0000);
    send(1, 1, 2'b10, 5'd1, 0); quiet(20);
    chk("R3 missing second command", err_reg, 16'h0008);
    clear_all();

    cur_req = "R5";
    send(1, 1, 2'b00, 5'd3, 0); data(1); quiet(20);
    chk("R5 gap inside receive", err_reg, 16'h0021);
    clear_all();
    send(1, 1, 2'b00, 5'd2, 0); data(1); quiet(CON - 1); data(1); quiet(20);
    chk("R5 gap one cycle short", err_reg, 16'h0000);

    cur_req = "R6";
    send(1, 1, 2'b10, 5'd2, 0); send(1, 1, 2'b00, 5'd0, 0); quiet(RESP - 1);
    chk("R6 before timeout", err_reg, 16'h0000);
    quiet(1);
    chk("R6 no-response timeout", err_reg, 16'h0001);
    clear_all();
    send(1, 1, 2'b11, 5'd2, 0); send(1, 1, 2'b00, 5'd0, 0); quiet(30);
    send(1, 1, 2'b00, 5'd0, 0); data(2); quiet(20);
    chk("R6 status inside window clean", err_reg, 16'h0000);

    cur_req = "R7";
    send(1, 1, 2'b01, 5'd4, 1);
    chk("R7 transmit with empty fifo", err_reg, 16'h0080);
    clear_all();

    cur_req = "R12";
    send(1, 1, 2'b00, 5'd0, 0); data(32); quiet(20);
    chk("R12 count zero means 32", err_reg, 16'h0000);
    send(1, 1, 2'b00, 5'd0, 0); data(31); quiet(20);
    chk("R12 31 of 32 words", err_reg, 16'h0021);
    clear_all();

    cur_req = "R8";
    do_reset(5'b00001, 1'b1);
    chk("R8 bad address parity", err_reg, 16'h0200);
    chk("R10 pulse for parity", {15'd0, err_pulse}, 16'h0001);
    auto_clr = 1; quiet(20); auto_clr = 0;
    chk("R8 parity survives auto-clear", err_reg, 16'h0200);
    do_reset(5'b00001, 1'b0);
    chk("R8 good parity", err_reg, 16'h0000);
    rt_addr = 5'b00011; quiet(5);
    chk("R8 late address change ignored", err_reg, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule